// File: doc/BRIEF.md
# SD Clock Source Switch Sequencer

This block drives the 2-bit source selector of one SD-card clock domain. Three sources can be chosen: a 533 MHz, a 400 MHz and a 266 MHz clock. A client presents a source index on a request/acknowledge interface. The block then issues one or two masked register writes to the selector field. After each write it waits for the domain's switch status bit to drop. It ends the sequence with a done pulse, or with a timeout pulse if the status stays high too long.

Moving straight between the 533 and 400 MHz settings is not allowed. For either of those targets the block first parks the selector on 266 MHz and waits for that switch to finish. The selector code zero is illegal and is never written. When the block is idle and reads the selector back as zero, it rewrites the reset default of 533 MHz. Two instances can share one status word, and each instance watches its own status bit, chosen by a parameter.

Top module: `sdclk_src_seq`

## Requirements
- R1: A request for index 0, 1 or 2 ends with the selector code index+1 written into the field at bit FIELD_LSB: code 2'b01 is 533 MHz, 2'b10 is 400 MHz and 2'b11 is 266 MHz.
- R2: Every write word has the two write-enable bits at FIELD_LSB+16 set and the code in the field. All other bits are zero.
- R3: The code 2'b00 is never written. A request with index 3 is not acknowledged and causes no write.
- R4: For index 0 or 1 the first write carries code 2'b11. The target code is written only after the status bit has been seen low following that first write.
- R5: For index 2 exactly one write, of code 2'b11, is made.
- R6: The status bit is sampled from the second cycle after each write. After TIMEOUT_CYC+1 consecutive high samples the block pulses timeout_o, drops busy_o and makes no further write. A status that is high for TIMEOUT_CYC samples and then low lets the sequence go on.
- R7: busy_o is high from the cycle of the first write until the cycle in which done_o or timeout_o pulses. Each of these pulses lasts one cycle, and they never occur together.
- R8: A request that arrives while busy_o is high is not acknowledged and adds no write.
- R9: When the block is idle with no accepted request and sel_cur_i reads 2'b00, it writes code 2'b01 and finishes with done_o as for a switch.
- R10: Only bit STAT_SEL of stat_i is watched. The other status bits have no effect.
- R11: After reset, busy_o, done_o, timeout_o, wr_en_o and ack_o are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Switch request |
| req_idx_i | input | 2 | Requested source index (0..2 valid) |
| ack_o | output | 1 | Request accepted this cycle |
| sel_cur_i | input | 2 | Current selector field read back |
| stat_i | input | STAT_W | Switch status bits, high while a switch is in progress |
| wr_en_o | output | 1 | Selector register write strobe |
| wr_data_o | output | DATA_W | Masked write word |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence completed (one cycle) |
| timeout_o | output | 1 | Status wait expired (one cycle) |

## Verification
The bench sweeps every index against status busy lengths on both sides of the timeout limit. The two lengths one apart at the limit catch an off-by-one in the wait counter, which would show up as a missing timeout or a spurious one. The unused status bit is held high all the time, so a design that watches the wrong bit times out on every request. The checks also cover a second request issued mid-sequence, which a missing busy guard would turn into an extra write, and a forced zero selector, which must produce a single 533 MHz repair write. A design that skipped the 266 MHz step, or wrote the target before the status cleared, would fail the write-log comparison.

// File: rtl/sdsw_pkg.sv
package sdsw_pkg;
  localparam int SEL_W = 2;
  localparam logic [SEL_W-1:0] CODE_533 = 2'b01;
  localparam logic [SEL_W-1:0] CODE_400 = 2'b10;
  localparam logic [SEL_W-1:0] CODE_266 = 2'b11;
  localparam logic [SEL_W-1:0] IDX_BAD  = 2'b11;

  typedef enum logic [1:0] {ST_IDLE, ST_MID, ST_FIN} sdsw_state_e;

  function automatic logic [SEL_W-1:0] idx2code(input logic [SEL_W-1:0] idx);
    return idx + 2'd1;
  endfunction
endpackage

// File: rtl/sdsw_wr_fmt.sv
module sdsw_wr_fmt
  import sdsw_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int FIELD_LSB = 0
) (
  input  logic [SEL_W-1:0]  code_i,
  output logic [DATA_W-1:0] word_o
);
  localparam int WEN_LSB = FIELD_LSB + 16;

  always_comb begin
    word_o = '0;
    word_o[FIELD_LSB +: SEL_W] = code_i;
    word_o[WEN_LSB +: SEL_W]   = '1;
  end
endmodule

// File: rtl/sdsw_wait_timer.sv
module sdsw_wait_timer #(
  parameter int TIMEOUT_CYC = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic stat_i,
  output logic clear_o,
  output logic expire_o
);
  localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);

  logic             run_q, armed_q;
  logic [CNT_W-1:0] cnt_q;
  logic             sample;

  // first cycle after a write is a settle cycle: status not yet valid
  assign sample   = run_q && armed_q;
  assign clear_o  = sample && !stat_i;
  assign expire_o = sample && stat_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (start_i) begin
      run_q   <= 1'b1;
      armed_q <= 1'b0;
      cnt_q   <= CNT_W'(TIMEOUT_CYC);
    end else if (clear_o || expire_o) begin
      run_q   <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      armed_q <= run_q;
      if (sample) cnt_q <= cnt_q - 1'b1;
    end
  end

  a_r6_settle_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !clear_o && !expire_o);
  a_r6_single_outcome: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(clear_o && expire_o));
endmodule

// File: rtl/sdclk_src_seq.sv
module sdclk_src_seq
  import sdsw_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int FIELD_LSB   = 0,
  parameter int STAT_W      = 2,
  parameter int STAT_SEL    = 0,
  parameter int TIMEOUT_CYC = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [1:0]        req_idx_i,
  output logic              ack_o,
  input  logic [1:0]        sel_cur_i,
  input  logic [STAT_W-1:0] stat_i,
  output logic              wr_en_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              timeout_o
);
  localparam int WEN_LSB = FIELD_LSB + 16;

  sdsw_state_e      state_q;
  logic [SEL_W-1:0] target_q, wr_code_q, next_code;
  logic             wr_en_q, busy_q, done_q, to_q;
  logic             stat_bit, accept, repair, start, clr, exp_w;

  generate
    if (STAT_W == 1) begin : g_stat_one
      assign stat_bit = stat_i[0];
    end else begin : g_stat_sel
      assign stat_bit = stat_i[STAT_SEL];
    end
  endgenerate

  assign accept = (state_q == ST_IDLE) && req_i && (req_idx_i != IDX_BAD);
  assign repair = (state_q == ST_IDLE) && !accept && (sel_cur_i == 2'b00);
  assign start  = accept || repair || ((state_q == ST_MID) && clr);
  assign ack_o  = accept;

  always_comb begin
    next_code = target_q;
    if (accept)      next_code = CODE_266;
    else if (repair) next_code = CODE_533;
  end

  sdsw_wait_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .stat_i   (stat_bit),
    .clear_o  (clr),
    .expire_o (exp_w)
  );

  sdsw_wr_fmt #(.DATA_W(DATA_W), .FIELD_LSB(FIELD_LSB)) u_fmt (
    .code_i (wr_code_q),
    .word_o (wr_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      target_q  <= CODE_533;
      wr_code_q <= CODE_533;
      wr_en_q   <= 1'b0;
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      to_q      <= 1'b0;
    end else begin
      wr_en_q <= start;
      done_q  <= 1'b0;
      to_q    <= 1'b0;
      if (start) wr_code_q <= next_code;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            busy_q   <= 1'b1;
            target_q <= idx2code(req_idx_i);
            state_q  <= (req_idx_i == 2'd2) ? ST_FIN : ST_MID;
          end else if (repair) begin
            busy_q  <= 1'b1;
            state_q <= ST_FIN;
          end
        end
        ST_MID: begin
          if (clr) state_q <= ST_FIN;
          else if (exp_w) begin
            to_q    <= 1'b1;
            busy_q  <= 1'b0;
            state_q <= ST_IDLE;
          end
        end
        ST_FIN: begin
          if (clr || exp_w) begin
            done_q  <= clr;
            to_q    <= exp_w;
            busy_q  <= 1'b0;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign wr_en_o   = wr_en_q;
  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign timeout_o = to_q;

  // checker state: code of the previous write
  logic [SEL_W-1:0] last_code_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      last_code_q <= 2'b00;
    else if (wr_en_o) last_code_q <= wr_data_o[FIELD_LSB +: SEL_W];
  end

  a_r3_no_zero_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> wr_data_o[FIELD_LSB +: SEL_W] != 2'b00);
  a_r2_wen_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> wr_data_o[WEN_LSB +: SEL_W] == 2'b11);
  a_r4_400_after_266: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && wr_data_o[FIELD_LSB +: SEL_W] == CODE_400) |-> last_code_q == CODE_266);
  a_r7_busy_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (done_o || timeout_o));
  a_r7_one_outcome: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && timeout_o));
  a_r6_no_write_on_timeout: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> !wr_en_o);
  a_r8_no_ack_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !ack_o);
  a_r7_write_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |=> !wr_en_o);
endmodule

// File: tb/sdclk_src_seq_tb.sv
module sdclk_src_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TO  = 8;
  localparam int LSB = 4;
  localparam int SEL = 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [1:0]  idx = 2'd0;
  logic        ack, busy, done, tmo, wr_en;
  logic [31:0] wr_data;
  logic [1:0]  sel_cur;
  logic [1:0]  stat;
  logic        st;
  int          hc;
  int          dly = 3;
  logic        zap = 1'b0;
  int          wr_total;
  logic [31:0] log_q [32];
  int          checks = 0;
  int          errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdclk_src_seq #(.DATA_W(32), .FIELD_LSB(LSB), .STAT_W(2), .STAT_SEL(SEL),
                  .TIMEOUT_CYC(TO)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .req_idx_i(idx), .ack_o(ack),
    .sel_cur_i(sel_cur), .stat_i(stat), .wr_en_o(wr_en), .wr_data_o(wr_data),
    .busy_o(busy), .done_o(done), .timeout_o(tmo)
  );

  // status model on bit SEL; the other bit is held high (R10)
  assign stat = {st, 1'b1};

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= 1'b0; hc <= 0; sel_cur <= 2'b01; wr_total <= 0;
    end else begin
      if (wr_en) begin
        st <= 1'b1; hc <= dly - 1;
        log_q[wr_total % 32] <= wr_data;
        wr_total <= wr_total + 1;
      end else if (st) begin
        if (hc != 0) hc <= hc - 1;
        else st <= 1'b0;
      end
      if (zap) sel_cur <= 2'b00;
      else if (wr_en && wr_data[LSB+16 +: 2] == 2'b11) sel_cur <= wr_data[LSB +: 2];
    end
  end

  function automatic logic [31:0] word(input int code);
    return (32'h3 << (LSB + 16)) | (32'(code) << LSB);
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_outcome(output int bad_busy, output bit hung, input bit poke);
    int n = 0;
    bad_busy = 0;
    while (!(done || tmo) && n < 200) begin
      if (!busy) bad_busy++;
      if (poke && n == 1) begin req = 1'b1; idx = 2'd2; end
      else req = 1'b0;
      @(negedge clk);
      n++;
    end
    req = 1'b0;
    hung = (n >= 200);
    if (hung) check(1'b0, "watchdog", n, 0);
  endtask

  task automatic run_case(input int i, input int d, input bit poke);
    int base, nw, bad_busy, last;
    bit exp_to, hung;
    base = wr_total;
    dly = d;
    @(negedge clk);
    req = 1'b1; idx = 2'(i);
    #1;
    check(ack == (i != 3), (i == 3) ? "R3 ack on index 3" : "R1 ack", ack, i != 3);
    @(negedge clk);
    req = 1'b0;
    if (i == 3) begin
      repeat (5) @(negedge clk);
      check(wr_total == base, "R3 no write for index 3", wr_total - base, 0);
      check(!busy, "R3 not busy for index 3", busy, 0);
      return;
    end
    wait_outcome(bad_busy, hung, poke);
    if (hung) return;
    exp_to = (d > TO);
    nw = (i == 2) ? 1 : (exp_to ? 1 : 2);
    check(done == !exp_to, "R6 done outcome", done, !exp_to);
    check(tmo == exp_to, "R6 timeout outcome", tmo, exp_to);
    check(bad_busy == 0, "R7 busy held", bad_busy, 0);
    check(wr_total - base == nw, (i == 2) ? "R5 write count" : "R4 write count",
          wr_total - base, nw);
    check(log_q[base % 32] == word(3), "R2 first word is 266 step", log_q[base % 32], word(3));
    if (nw == 2)
      check(log_q[(base + 1) % 32] == word(i + 1), "R1 target word",
            log_q[(base + 1) % 32], word(i + 1));
    last = (nw == 2) ? i + 1 : 3;
    check(sel_cur == 2'(last), "R1 selector value", sel_cur, last);
    @(negedge clk);
    check(!done && !tmo, "R7 outcome is a pulse", {done, tmo}, 0);
    repeat (d + 4) @(negedge clk);
    check(wr_total - base == nw, poke ? "R8 no write from busy request" : "R6 no late write",
          wr_total - base, nw);
  endtask

  initial begin
    int bad_busy;
    bit hung;
    int base;
    int dl [5] = '{1, 3, 8, 9, 12};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && !tmo && !wr_en && !ack, "R11 reset state",
          {busy, done, tmo, wr_en, ack}, 0);
    for (int i = 0; i < 4; i++)
      for (int k = 0; k < 5; k++)
        run_case(i, dl[k], dl[k] == 3);
    // repair of prohibited selector value (R9)
    base = wr_total;
    dly = 2;
    zap = 1'b1;
    @(negedge clk);
    zap = 1'b0;
    @(negedge clk);
    wait_outcome(bad_busy, hung, 1'b0);
    if (!hung) begin
      check(done, "R9 repair done", done, 1);
      check(wr_total - base == 1, "R9 repair write count", wr_total - base, 1);
      check(log_q[base % 32] == word(1), "R9 repair word", log_q[base % 32], word(1));
      check(sel_cur == 2'b01, "R9 selector restored", sel_cur, 1);
    end
    repeat (6) @(negedge clk);
    check(wr_total - base == 1, "R9 single repair", wr_total - base, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule